// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine moves outgoing frames from memory onto a byte stream by walking a linked list of transmit descriptors. Software builds descriptors in memory, points the engine at the head of the list, turns transmission on and pulses a start strobe. The engine then works through the list on its own. For each descriptor that hands the frame to hardware, it reads the frame buffer word by word and streams the bytes out. It then writes the descriptor back with ownership returned and a completion status, and follows the next-descriptor pointer. It stops when it meets a descriptor that software still owns, or when a descriptor fetch fails.

Memory is reached through a word-addressed request port with a single outstanding transaction. A request holds its address, write flag and write data stable until `mem_req_ready` accepts it. Exactly one response follows, carrying read data and an error bit. The frame leaves on a valid/ready byte stream with a last marker. Once `tx_valid` is high, the byte and the marker stay unchanged until `tx_ready` accepts them, and the consumer may hold `tx_ready` low for any number of cycles. Three one-cycle event pulses feed an external interrupt unit. That unit returns its transmit summary level on `irq_summary`, which the engine copies into the descriptor it writes back.

Top module: `txring_engine`

## Requirements
- R1: After reset, `cur_desc` and `cur_buf` are 0, and `tx_halted`, `busy`, `tx_valid`, `mem_req_valid` and all event outputs are low.
- R2: A rising edge of `tx_en` loads `cur_desc` from `list_base` and clears `tx_halted` one cycle later. A falling edge sets `tx_halted` one cycle later. The descriptor in progress still completes, including write-back, but no further descriptor is fetched.
- R3: A one-cycle `tx_kick` while `tx_en` is high starts processing at `cur_desc`, and the engine continues until it halts. A `tx_kick` while `tx_en` is low is ignored: no memory request is made and no byte is sent.
- R4: A descriptor is four words at `cur_desc`+0..3. Word 0 holds the flags: bit 31 is ownership (1 = engine), bit 0 enables padding and bit 2 enables the completion interrupt. Word 1 is the buffer word address, word 2 holds the length in bytes in bits [15:0], and word 3 is the next descriptor address. If bit 31 of word 0 is clear, the engine halts and pulses `ev_unavail`, sends no byte, writes nothing and leaves `cur_desc` unchanged.
- R5: Frame byte k is bits [8j+7:8j] of buffer word `buffer+k/4`, where j = k mod 4. Bytes leave in increasing k, and `tx_last` marks only the final byte.
- R6: When the pad flag is set and the length is below 60, zero bytes follow the data up to 60 bytes in total. Otherwise exactly the length is sent, so a zero length without padding sends no byte.
- R7: Write-back stores word 0 with bit 31 cleared and the other flags kept. It stores word 2 with the length kept, bits [31:16] cleared, and bit 16 (complete) set when the buffer read succeeded. Words 1 and 3 are not written.
- R8: `ev_done` pulses once per successfully sent descriptor, and only when its interrupt-enable flag is set.
- R9: Bit 17 of the written word 2 is set when `irq_summary` is high as the flags write-back completes and the buffer read succeeded.
- R10: An error response to any descriptor fetch pulses `ev_buserr` and halts the engine with no write-back and `cur_desc` unchanged.
- R11: An error response to a buffer read pulses `ev_buserr`. From that word on, the frame is sent as zero bytes at its full length. The descriptor is still written back, without bit 16, and the engine advances.
- R12: `cur_buf` takes word 1 of each accepted descriptor, and `cur_desc` takes word 3 after that descriptor's write-back.
- R13: `mem_req_valid` and its address, write flag and data stay stable until accepted, and `busy` is high while the engine is started or a descriptor is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable level |
| tx_kick | input | 1 | Start strobe |
| list_base | input | 32 | Head of the descriptor list (word address) |
| irq_summary | input | 1 | Transmit interrupt summary from the interrupt unit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| ev_done | output | 1 | Completion event pulse |
| ev_unavail | output | 1 | Software-owned descriptor event pulse |
| ev_buserr | output | 1 | Memory error event pulse |
| tx_halted | output | 1 | Transmission was turned off |
| busy | output | 1 | Engine started or descriptor in flight |
| cur_desc | output | 32 | Current descriptor address |
| cur_buf | output | 32 | Buffer address of the latest accepted descriptor |

## Verification
`cur_desc` and `tx_halted` respond at the first clock edge after an edge of `tx_en`. The bench drives that edge between clock edges and reads the result half a cycle after the following edge. Event pulses are registered one cycle after the deciding memory response. The bench therefore counts them continuously at falling clock edges and compares only the totals once `busy` has dropped. Stream bytes can arrive at any cycle under back-pressure, so a scoreboard queue matches them in order rather than by cycle, and descriptor memory is read back only after `busy` is low.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int OWN_BIT  = 31;
  localparam int PAD_BIT  = 0;
  localparam int IEN_BIT  = 2;
  localparam int DONE_BIT = 16;
  localparam int COPY_BIT = 17;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_FRAME, S_BREQ, S_BWAIT, S_SEND, S_WREQ, S_WWAIT
  } seq_state_t;
endpackage

// File: rtl/txr_gate.sv
module txr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic kick,
  input  logic stop_req,
  output logic active,
  output logic halted,
  output logic load_ptr
);
  logic en_q;
  logic en_fall;

  assign load_ptr = tx_en & ~en_q;
  assign en_fall  = ~tx_en & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      active <= 1'b0;
      halted <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (en_fall || stop_req) active <= 1'b0;
      else if (kick && tx_en) active <= 1'b1;
      if (en_fall) halted <= 1'b1;
      else if (load_ptr) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/txr_bytes.sv
module txr_bytes #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   load_word,
  input  logic          send,
  input  logic [LW-1:0] byte_cnt,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] eff_len,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last
);
  logic [31:0] word_q;
  logic        in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (load) word_q <= load_word;
  end

  // bytes past the programmed length are padding and always zero
  assign in_data  = byte_cnt < len;
  assign tx_data  = in_data ? word_q[{byte_cnt[1:0], 3'b000} +: 8] : 8'h00;
  assign tx_valid = send;
  assign tx_last  = send && (byte_cnt == eff_len - LW'(1));
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txring_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int MINLEN = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          load_ptr,
  input  logic [AW-1:0] list_base,
  input  logic          irq_summary,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  input  logic          mem_rsp_err,
  input  logic          tx_ready,
  output logic          send,
  output logic [LW-1:0] byte_cnt,
  output logic [LW-1:0] d_len,
  output logic [LW-1:0] eff_len,
  output logic          load,
  output logic [31:0]   load_word,
  output logic          stop_req,
  output logic          idle,
  output logic          ev_done,
  output logic          ev_unavail,
  output logic          ev_buserr,
  output logic [AW-1:0] cur_desc,
  output logic [AW-1:0] cur_buf
);
  localparam logic [LW-1:0] MIN_L = LW'(MINLEN);
  localparam int IW = $clog2(DESC_WORDS);

  seq_state_t    state;
  logic [IW-1:0] idx;
  logic [31:0]   d_flags;
  logic [AW-1:0] d_buf;
  logic [AW-1:0] d_next;
  logic          poison;
  logic          wsel;
  logic          copy_q;
  logic [LW:0]   cnt_nxt;
  logic          last_hit;
  logic          need_read;
  logic          rsp_owned;
  logic [31:0]   wb_status;

  assign eff_len   = (d_flags[PAD_BIT] && d_len < MIN_L) ? MIN_L : d_len;
  assign cnt_nxt   = {1'b0, byte_cnt} + 1'b1;
  assign last_hit  = cnt_nxt == {1'b0, eff_len};
  assign need_read = (byte_cnt < d_len) && !poison;
  assign rsp_owned = mem_rsp_rdata[OWN_BIT];
  assign idle      = state == S_IDLE;
  assign send      = state == S_SEND;

  // combinational so that the gate drops 'active' on the same edge the sequencer idles
  assign stop_req = (state == S_DWAIT) && mem_rsp_valid &&
                    (mem_rsp_err || (idx == '0 && !rsp_owned));

  assign load      = (state == S_FRAME && !need_read) || (state == S_BWAIT && mem_rsp_valid);
  assign load_word = (state == S_BWAIT && !mem_rsp_err) ? mem_rsp_rdata : 32'h0;

  always_comb begin
    wb_status = 32'(d_len);
    wb_status[DONE_BIT] = ~poison;
    wb_status[COPY_BIT] = copy_q & ~poison;
  end

  assign mem_req_valid = (state == S_DREQ) || (state == S_BREQ) || (state == S_WREQ);
  assign mem_req_we    = state == S_WREQ;
  assign mem_req_wdata = wsel ? wb_status : (d_flags & ~(32'h1 << OWN_BIT));

  always_comb begin
    case (state)
      S_DREQ:  mem_req_addr = cur_desc + AW'(idx);
      S_BREQ:  mem_req_addr = d_buf + AW'(byte_cnt[LW-1:2]);
      S_WREQ:  mem_req_addr = cur_desc + (wsel ? AW'(2) : AW'(0));
      default: mem_req_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      d_flags    <= '0;
      d_buf      <= '0;
      d_len      <= '0;
      d_next     <= '0;
      byte_cnt   <= '0;
      poison     <= 1'b0;
      wsel       <= 1'b0;
      copy_q     <= 1'b0;
      ev_done    <= 1'b0;
      ev_unavail <= 1'b0;
      ev_buserr  <= 1'b0;
      cur_desc   <= '0;
      cur_buf    <= '0;
    end else begin
      ev_done    <= 1'b0;
      ev_unavail <= 1'b0;
      ev_buserr  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (active) begin
            idx   <= '0;
            state <= S_DREQ;
          end
        end
        S_DREQ: if (mem_req_ready) state <= S_DWAIT;
        S_DWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              ev_buserr <= 1'b1;
              state     <= S_IDLE;
            end else if (idx == '0 && !rsp_owned) begin
              ev_unavail <= 1'b1;
              state      <= S_IDLE;
            end else begin
              case (idx)
                IW'(0): d_flags <= mem_rsp_rdata;
                IW'(1): begin
                  d_buf   <= mem_rsp_rdata[AW-1:0];
                  cur_buf <= mem_rsp_rdata[AW-1:0];
                end
                IW'(2): d_len <= mem_rsp_rdata[LW-1:0];
                default: d_next <= mem_rsp_rdata[AW-1:0];
              endcase
              if (idx == IW'(DESC_WORDS - 1)) begin
                byte_cnt <= '0;
                poison   <= 1'b0;
                wsel     <= 1'b0;
                if (eff_len == '0) begin
                  ev_done <= d_flags[IEN_BIT];
                  state   <= S_WREQ;
                end else begin
                  state <= S_FRAME;
                end
              end else begin
                idx   <= idx + 1'b1;
                state <= S_DREQ;
              end
            end
          end
        end
        S_FRAME: state <= need_read ? S_BREQ : S_SEND;
        S_BREQ:  if (mem_req_ready) state <= S_BWAIT;
        S_BWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              poison    <= 1'b1;
              ev_buserr <= 1'b1;
            end
            state <= S_SEND;
          end
        end
        S_SEND: begin
          if (tx_ready) begin
            byte_cnt <= cnt_nxt[LW-1:0];
            if (last_hit) begin
              ev_done <= d_flags[IEN_BIT] & ~poison;
              wsel    <= 1'b0;
              state   <= S_WREQ;
            end else if (byte_cnt[1:0] == 2'b11) begin
              state <= S_FRAME;
            end
          end
        end
        S_WREQ: if (mem_req_ready) state <= S_WWAIT;
        S_WWAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) ev_buserr <= 1'b1;
            if (!wsel) begin
              wsel   <= 1'b1;
              copy_q <= irq_summary;
              state  <= S_WREQ;
            end else begin
              cur_desc <= d_next;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
      if (load_ptr) cur_desc <= list_base;
    end
  end
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int MINLEN = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tx_kick,
  input  logic [AW-1:0] list_base,
  input  logic          irq_summary,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata,
  input  logic          mem_rsp_err,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          ev_done,
  output logic          ev_unavail,
  output logic          ev_buserr,
  output logic          tx_halted,
  output logic          busy,
  output logic [AW-1:0] cur_desc,
  output logic [AW-1:0] cur_buf
);
  logic          active;
  logic          load_ptr;
  logic          stop_req;
  logic          idle;
  logic          send;
  logic          load;
  logic [31:0]   load_word;
  logic [LW-1:0] byte_cnt;
  logic [LW-1:0] d_len;
  logic [LW-1:0] eff_len;

  txr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .kick(tx_kick), .stop_req(stop_req),
    .active(active), .halted(tx_halted), .load_ptr(load_ptr)
  );

  txr_seq #(.AW(AW), .LW(LW), .MINLEN(MINLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .load_ptr(load_ptr),
    .list_base(list_base), .irq_summary(irq_summary),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
    .tx_ready(tx_ready), .send(send), .byte_cnt(byte_cnt), .d_len(d_len), .eff_len(eff_len),
    .load(load), .load_word(load_word), .stop_req(stop_req), .idle(idle),
    .ev_done(ev_done), .ev_unavail(ev_unavail), .ev_buserr(ev_buserr),
    .cur_desc(cur_desc), .cur_buf(cur_buf)
  );

  txr_bytes #(.LW(LW)) u_bytes (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word), .send(send),
    .byte_cnt(byte_cnt), .len(d_len), .eff_len(eff_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last)
  );

  assign busy = active | ~idle;
endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic [AW-1:0] list_base,
  input logic [AW-1:0] cur_desc,
  input logic          tx_halted,
  input logic          busy,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          ev_done,
  input logic          ev_unavail,
  input logic          ev_buserr
);
  assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_rise_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> cur_desc == $past(list_base));

  assert_fall_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> tx_halted);

  assert_unavail_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |-> !busy && !mem_req_valid);

  assert_wb_after_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !tx_valid);

  assert_event_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_done, ev_unavail, ev_buserr}));
endmodule

bind txring_engine txring_chk u_chk (.*);

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] PAD = 32'h0000_0001;
  localparam logic [31:0] IEN = 32'h0000_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        tx_kick = 1'b0;
  logic [31:0] list_base = 32'h0;
  logic        irq_summary = 1'b0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = 32'h0;
  logic        mem_rsp_err = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b1;
  logic        ev_done, ev_unavail, ev_buserr, tx_halted, busy;
  logic [31:0] cur_desc, cur_buf;

  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int          mcnt = 0;
  int          rcnt = 0;
  bit          ready_pattern = 1'b0;
  logic [8:0]  exp_q [$];
  int          n_checks = 0;
  int          n_errors = 0;
  int          n_done = 0, n_unavail = 0, n_buserr = 0;
  int          byte_idx = 0;

  always #2 clk = ~clk;

  txring_engine u0 (.*);

  // memory model: one response per accepted request, one cycle later
  always @(posedge clk) begin
    mcnt <= mcnt + 1;
    mem_req_ready <= (mcnt % 5) != 3;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= (mem_req_addr == err_addr);
      mem_rsp_rdata <= mem[mem_req_addr[7:0]];
      if (mem_req_we && mem_req_addr != err_addr) mem[mem_req_addr[7:0]] <= mem_req_wdata;
    end
  end

  always @(posedge clk) begin
    #1;
    rcnt <= rcnt + 1;
    tx_ready <= ready_pattern ? ((rcnt % 4) != 2) : 1'b1;
  end

  // monitor: scoreboard pop and event counting
  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_done) n_done++;
      if (ev_unavail) n_unavail++;
      if (ev_buserr) n_buserr++;
      if (tx_valid && tx_ready) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_errors++;
          $display("FAIL R5: unexpected byte %h last %b, expected none", tx_data, tx_last);
        end else begin
          if ({tx_last, tx_data} !== exp_q[0]) begin
            n_errors++;
            $display("FAIL R5/R6: byte %0d got %h expected %h", byte_idx, {tx_last, tx_data}, exp_q[0]);
          end
          void'(exp_q.pop_front());
        end
        byte_idx++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] fl, input logic [31:0] bufa,
                          input logic [31:0] w2, input logic [31:0] nxt);
    mem[a[7:0]] = fl; mem[a[7:0]+8'd1] = bufa; mem[a[7:0]+8'd2] = w2; mem[a[7:0]+8'd3] = nxt;
  endtask

  task automatic fill_buf(input logic [31:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      mem[a[7:0] + 8'(i)] = {seed ^ 8'(i), 8'h11 + 8'(i), 8'h5A ^ seed, 8'h3C + 8'(3*i)};
  endtask

  // driver: expected bytes per R5/R6/R11
  task automatic push_frame(input logic [31:0] a, input int len, input bit pad, input int errw);
    int eff;
    eff = (pad && len < 60) ? 60 : len;
    for (int k = 0; k < eff; k++) begin
      logic [7:0] b;
      logic [31:0] w;
      w = mem[a[7:0] + 8'(k/4)];
      b = (k < len && (errw < 0 || k/4 < errw)) ? w[8*(k%4) +: 8] : 8'h00;
      exp_q.push_back({(k == eff-1), b});
    end
  endtask

  task automatic kick_and_wait();
    @(negedge clk) tx_kick = 1'b1;
    @(negedge clk) tx_kick = 1'b0;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    int d0, u0c, b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cur_desc", cur_desc, 0);
    chk("R1 cur_buf", cur_buf, 0);
    chk("R1 halted", {31'd0, tx_halted}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 valid", {30'd0, tx_valid, mem_req_valid}, 0);

    // R2 rising edge loads pointer
    list_base = 32'h10;
    tx_en = 1'b1;
    @(negedge clk);
    chk("R2 load on rise", cur_desc, 32'h10);

    // chain: interrupt-enabled short frame, padded frame, software-owned stop
    ready_pattern = 1'b1;
    irq_summary = 1'b0;
    fill_buf(32'h80, 2, 8'h21);
    fill_buf(32'h90, 3, 8'h42);
    put_desc(32'h10, OWN | IEN | 32'h100, 32'h80, 32'd5, 32'h20);
    put_desc(32'h20, OWN | PAD, 32'h90, 32'h55AA_000A, 32'h30);
    put_desc(32'h30, 32'h0, 32'hA0, 32'h1234_0003, 32'h40);
    push_frame(32'h80, 5, 1'b0, -1);
    push_frame(32'h90, 10, 1'b1, -1);
    d0 = n_done; u0c = n_unavail; b0 = n_buserr;
    kick_and_wait();
    chk("R5 stream drained", exp_q.size(), 0);
    chk("R7 flags wb A", mem[8'h10], 32'h0000_0104);
    chk("R7 status wb A", mem[8'h12], 32'h0001_0005);
    chk("R7 flags wb B", mem[8'h20], 32'h0000_0001);
    chk("R7 status cleared B", mem[8'h22], 32'h0001_000A);
    chk("R7 word3 untouched", mem[8'h13], 32'h20);
    chk("R8 done once", n_done - d0, 1);
    chk("R4 unavail", n_unavail - u0c, 1);
    chk("R4 owner word untouched", mem[8'h30], 32'h0);
    chk("R4 status untouched", mem[8'h32], 32'h1234_0003);
    chk("R12 cur_desc", cur_desc, 32'h30);
    chk("R12 cur_buf", cur_buf, 32'h90);
    chk("R10 no buserr", n_buserr - b0, 0);

    // R3 resume at software-owned slot, R9 copy bit, pad flag with long frame
    ready_pattern = 1'b0;
    irq_summary = 1'b1;
    fill_buf(32'hA0, 16, 8'h63);
    put_desc(32'h30, OWN | PAD | IEN, 32'hA0, 32'd64, 32'h40);
    put_desc(32'h40, 32'h0, 32'hB0, 32'd8, 32'h50);
    push_frame(32'hA0, 64, 1'b1, -1);
    d0 = n_done; u0c = n_unavail;
    kick_and_wait();
    chk("R6 no pad at 64", exp_q.size(), 0);
    chk("R9 copy bit", mem[8'h32], 32'h0003_0040);
    chk("R8 done", n_done - d0, 1);
    chk("R3 resumed and stopped", cur_desc, 32'h40);

    // R11 buffer read error
    fill_buf(32'hB0, 2, 8'h84);
    put_desc(32'h40, OWN | IEN, 32'hB0, 32'd8, 32'h50);
    put_desc(32'h50, 32'h0, 32'hC0, 32'd5, 32'h60);
    err_addr = 32'hB1;
    push_frame(32'hB0, 8, 1'b0, 1);
    d0 = n_done; b0 = n_buserr;
    kick_and_wait();
    chk("R11 zero-filled stream", exp_q.size(), 0);
    chk("R11 buserr", n_buserr - b0, 1);
    chk("R11 no done", n_done - d0, 0);
    chk("R11 wb flags", mem[8'h40], 32'h0000_0004);
    chk("R11 wb status", mem[8'h42], 32'h0000_0008);
    chk("R11 advanced", cur_desc, 32'h50);

    // R10 descriptor fetch error
    put_desc(32'h50, OWN, 32'hC0, 32'd5, 32'h60);
    err_addr = 32'h52;
    b0 = n_buserr;
    kick_and_wait();
    chk("R10 buserr", n_buserr - b0, 1);
    chk("R10 no wb", mem[8'h50], OWN);
    chk("R10 ptr kept", cur_desc, 32'h50);
    chk("R10 idle", {31'd0, busy}, 0);
    err_addr = 32'hFFFF_FFFF;

    // R2 falling edge, R3 kick ignored while disabled
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    chk("R2 halted", {31'd0, tx_halted}, 1);
    @(negedge clk) tx_kick = 1'b1;
    @(negedge clk) tx_kick = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 ignored busy", {31'd0, busy}, 0);
    chk("R3 ignored mem", mem[8'h50], OWN);
    chk("R3 ignored ptr", cur_desc, 32'h50);

    // R2 reload on rise, R6 zero-length cases
    irq_summary = 1'b0;
    list_base = 32'h60;
    put_desc(32'h60, OWN | IEN, 32'hC0, 32'd0, 32'h68);
    put_desc(32'h68, OWN | PAD | IEN, 32'hC8, 32'd0, 32'h70);
    put_desc(32'h70, 32'h0, 32'hD0, 32'd40, 32'h78);
    @(negedge clk) tx_en = 1'b1;
    @(negedge clk);
    chk("R2 reload", cur_desc, 32'h60);
    chk("R2 halted cleared", {31'd0, tx_halted}, 0);
    push_frame(32'hC8, 0, 1'b1, -1);
    d0 = n_done;
    kick_and_wait();
    chk("R6 zero-length stream", exp_q.size(), 0);
    chk("R6 zero-length wb", mem[8'h62], 32'h0001_0000);
    chk("R6 padded zero wb", mem[8'h6A], 32'h0001_0000);
    chk("R8 two done", n_done - d0, 2);

    // R2 disable mid-frame: current descriptor completes, next not fetched
    ready_pattern = 1'b1;
    fill_buf(32'hD0, 10, 8'hA5);
    put_desc(32'h70, OWN, 32'hD0, 32'd40, 32'h78);
    put_desc(32'h78, OWN, 32'hE0, 32'd4, 32'h7C);
    push_frame(32'hD0, 40, 1'b0, -1);
    @(negedge clk) tx_kick = 1'b1;
    @(negedge clk) tx_kick = 1'b0;
    while (!(tx_valid && tx_ready)) @(negedge clk);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R2 frame completed", exp_q.size(), 0);
    chk("R2 wb done", mem[8'h72], 32'h0001_0028);
    chk("R2 next untouched", mem[8'h78], OWN);
    chk("R12 stopped at next", cur_desc, 32'h78);
    chk("R2 halted after stop", {31'd0, tx_halted}, 1);
    finish_run();
  end
endmodule